// File: doc/BRIEF.md
# Self-Test Status and Stall Watchdog Pin

This block drives one status output pin that does two jobs at different times. While the chip comes out of reset, the pin reports the built-in self-test result. The pin is high while the self-test and array initialisation run. It then goes low for a fixed window of 16 cycles when result extraction begins. After that window it settles low for a pass, or high for a failure. External logic can read the verdict on the first rising edge of the serial-ROM clock.

Once the window has closed and the test has passed, the same pin becomes a retirement watchdog. If 2048 consecutive cycles pass with no instruction retired, the pin is raised for exactly 3 cycles. The stall count then starts again, so a stall that continues produces a pulse every 2051 cycles. The self-test engine, the array initialisation and the extraction sequencer are outside this block; each reaches it only as an input flag.

The controller is a six-state machine:
- `ST_IDLE`: pin low after reset.
- `ST_SELFTEST`: pin high.
- `ST_EXTRACT`: pin low for the window.
- `ST_RUN`: pin low while the watchdog counts.
- `ST_ALERT`: pin high for the pulse.
- `ST_FAILED`: pin high and sticky.

The state machine has these transitions:
- IDLE to SELFTEST when the busy flag is set.
- IDLE or SELFTEST to EXTRACT on the extraction strobe.
- SELFTEST back to IDLE if the busy flag drops without a strobe.
- EXTRACT to RUN (pass) or to FAILED (fail) when the window ends.
- RUN to ALERT when the stall timer trips.
- ALERT to RUN after the third pulse cycle.
- FAILED is left only by reset.

Top module: `stat_pin_ctrl`

## Requirements
- R1: A synchronous active-high `rst` drives `stat_pin` low and the machine to idle at the next clock edge. The pin stays low after reset until the busy flag or the strobe arrives. The pin is a register output and changes only at clock edges.
- R2: While `bist_busy` is 1 and no strobe has arrived, `stat_pin` is 1 from the edge after `bist_busy` is sampled high.
- R3: An `extract_strobe` sampled high in idle or self-test drives `stat_pin` low for exactly 16 consecutive cycles, starting at the next edge.
- R4: `bist_pass` is sampled in the last cycle of the 16-cycle window. If it is 1, `stat_pin` stays low afterwards.
- R5: If `bist_pass` is 0 in the last window cycle, `stat_pin` goes high at the next edge and stays high until reset. Later busy flags and strobes are ignored.
- R6: In normal operation, a run of 2048 consecutive cycles with `retire` at 0 raises `stat_pin` for exactly 3 cycles. The pulse starts at the edge that ends the 2048th such cycle.
- R7: A `retire` pulse clears the stall count. If the stall continues, the pulse repeats with 2048 low cycles followed by 3 high cycles.
- R8: A `retire` pulse during the 3-cycle pulse does not shorten it. The stall count is held at zero during the pulse and restarts afterwards.
- R9: The watchdog is disabled in idle, self-test and the extraction window. No pulse appears there, however long retirement stalls.
- R10: A latched failure overrides the watchdog. No pulse appears and `stat_pin` stays high without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high system reset |
| bist_busy | input | 1 | Self-test and array initialisation in progress |
| extract_strobe | input | 1 | Start of the result-extraction phase |
| bist_pass | input | 1 | Self-test verdict, 1 = pass |
| retire | input | 1 | An instruction retired this cycle |
| stat_pin | output | 1 | Registered status pin |

## Verification
The assertions check several rules on every cycle:
- The pin level that belongs to each state (R2, R3).
- The exit from the window (R3).
- The stickiness of the failed state (R5).
- The entry into the pulse and the pulse holding until its third cycle (R6, R8).
- The stall count clearing on retire and climbing by one otherwise (R7).
- The timer never tripping outside normal operation (R9).

Some behaviour only the bench scenarios can show, because it depends on exact cycle counts across long stretches. This covers the 16-cycle window length, the 2048-cycle stall threshold, the 2051-cycle repeat period, the sampling point of the verdict, and the failure overriding a long stall.

// File: rtl/stat_pin_pkg.sv
package stat_pin_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SELFTEST = 3'd1,
        ST_EXTRACT  = 3'd2,
        ST_RUN      = 3'd3,
        ST_ALERT    = 3'd4,
        ST_FAILED   = 3'd5
    } pin_state_e;

    // Pin level carried in each state.
    function automatic logic level_of(pin_state_e s);
        return (s == ST_SELFTEST) || (s == ST_ALERT) || (s == ST_FAILED);
    endfunction

endpackage

// File: rtl/span_counter.sv
// Counts consecutive enabled cycles; done marks the last one of LIMIT.
module span_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic done
);
    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign done = en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3/R8: the span counter never rests above its final value
    a_r3_span_bounded: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt_q <= LAST));

endmodule

// File: rtl/stall_timer.sv
// Counts consecutive no-retire cycles while enabled.
module stall_timer #(
    parameter int LIMIT = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic retire,
    output logic trip
);
    localparam int CNT_W = $clog2(LIMIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign trip = en && !retire && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en || retire || trip) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r7_retire_clears: assert property (@(posedge clk) disable iff (rst)
        (en && retire) |=> (cnt_q == '0));

    a_r7_stall_climbs: assert property (@(posedge clk) disable iff (rst)
        (en && !retire && (cnt_q != LAST)) |=> (cnt_q == $past(cnt_q) + 1'b1));

    a_r8_held_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0));

endmodule

// File: rtl/stat_pin_fsm.sv
module stat_pin_fsm
    import stat_pin_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bist_busy,
    input  logic extract_strobe,
    input  logic bist_pass,
    input  logic win_done,
    input  logic stall_trip,
    input  logic alert_done,
    output logic in_extract,
    output logic in_run,
    output logic in_alert,
    output logic pin_q
);
    pin_state_e state_q;
    pin_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (extract_strobe)  state_d = ST_EXTRACT;
                else if (bist_busy)  state_d = ST_SELFTEST;
            end
            ST_SELFTEST: begin
                if (extract_strobe)  state_d = ST_EXTRACT;
                else if (!bist_busy) state_d = ST_IDLE;
            end
            ST_EXTRACT: begin
                if (win_done) state_d = bist_pass ? ST_RUN : ST_FAILED;
            end
            ST_RUN: begin
                if (stall_trip) state_d = ST_ALERT;
            end
            ST_ALERT: begin
                if (alert_done) state_d = ST_RUN;
            end
            ST_FAILED: state_d = ST_FAILED;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Registered pin, decoded from the next state so it aligns with state_q
    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= level_of(state_d);
    end

    assign in_extract = (state_q == ST_EXTRACT);
    assign in_run     = (state_q == ST_RUN);
    assign in_alert   = (state_q == ST_ALERT);

    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> (!pin_q && state_q == ST_IDLE));

    a_r2_selftest_high: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SELFTEST) |-> pin_q);

    a_r3_window_low: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXTRACT) |-> !pin_q);

    a_r3_window_exit: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXTRACT && win_done) |=>
            (state_q == ST_RUN || state_q == ST_FAILED));

    a_r5_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FAILED) |=> (state_q == ST_FAILED && pin_q));

    a_r6_alert_entry: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && stall_trip) |=> (state_q == ST_ALERT && pin_q));

    a_r8_alert_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ALERT && !alert_done) |=> (state_q == ST_ALERT));

    a_r9_trip_only_in_run: assert property (@(posedge clk) disable iff (rst)
        stall_trip |-> (state_q == ST_RUN));

endmodule

// File: rtl/stat_pin_ctrl.sv
module stat_pin_ctrl #(
    parameter int WINDOW_CYCLES = 16,
    parameter int STALL_CYCLES  = 2048,
    parameter int ALERT_CYCLES  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic bist_busy,
    input  logic extract_strobe,
    input  logic bist_pass,
    input  logic retire,
    output logic stat_pin
);
    logic win_done;
    logic stall_trip;
    logic alert_done;
    logic in_extract;
    logic in_run;
    logic in_alert;

    stat_pin_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .bist_busy      (bist_busy),
        .extract_strobe (extract_strobe),
        .bist_pass      (bist_pass),
        .win_done       (win_done),
        .stall_trip     (stall_trip),
        .alert_done     (alert_done),
        .in_extract     (in_extract),
        .in_run         (in_run),
        .in_alert       (in_alert),
        .pin_q          (stat_pin)
    );

    span_counter #(.LIMIT(WINDOW_CYCLES)) u_window (
        .clk  (clk),
        .rst  (rst),
        .en   (in_extract),
        .done (win_done)
    );

    span_counter #(.LIMIT(ALERT_CYCLES)) u_alert (
        .clk  (clk),
        .rst  (rst),
        .en   (in_alert),
        .done (alert_done)
    );

    stall_timer #(.LIMIT(STALL_CYCLES)) u_stall (
        .clk    (clk),
        .rst    (rst),
        .en     (in_run),
        .retire (retire),
        .trip   (stall_trip)
    );

endmodule

// File: tb/stat_pin_ctrl_tb.sv
module stat_pin_ctrl_tb;

    typedef struct packed {
        logic        rst;
        logic        busy;
        logic        strb;
        logic        pass;
        logic        ret;
        logic        exp;
        logic [11:0] reps;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 35;

    // fields: rst busy strb pass ret exp reps req
    localparam vec_t VEC [NVEC] = '{
        // pass path
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,12'd3,   4'd1},  // R1 reset low
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,12'd5,   4'd2},  // R2 busy high
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,12'd1,   4'd3},  // R3 window start
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,12'd15,  4'd3},  // R3 window rest
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,12'd10,  4'd4},  // R4 pass low
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,12'd2047,4'd6},  // R6 stall below limit
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,12'd3,   4'd6},  // R6 pulse
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,12'd2048,4'd7},  // R7 repeat low
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,12'd1,   4'd7},  // R7 repeat pulse
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,12'd2,   4'd8},  // R8 retire in pulse
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,12'd1,   4'd8},  // R8 pulse ended on time
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,12'd1000,4'd7},  // R7 partial stall
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,12'd1,   4'd7},  // R7 retire clears
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,12'd2047,4'd7},  // R7 full count again
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,12'd3,   4'd7},  // R7 pulse
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,12'd5,   4'd6},  // R6 back low
        // fail path
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,12'd2,   4'd1},  // R1
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,12'd2100,4'd9},  // R9 idle, no pulse
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,12'd2100,4'd9},  // R9 selftest, no pulse
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,12'd1,   4'd3},  // R3
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,12'd15,  4'd3},  // R3 / R9
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,12'd3000,4'd10}, // R10 / R5 high through stall
        '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,12'd4,   4'd5},  // R5 later inputs ignored
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,12'd2,   4'd1},  // R1 reset clears failure
        // strobe straight from idle, pass sampled in last window cycle
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,12'd1,   4'd3},  // R3
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,12'd15,  4'd3},  // R3 pass still 0
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,12'd1,   4'd4},  // R4 sampled here
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,12'd20,  4'd4},  // R4 stays low
        // fail verdict sampled in last window cycle only
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,12'd2,   4'd1},  // R1
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,12'd3,   4'd2},  // R2
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,12'd1,   4'd3},  // R3
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,12'd15,  4'd3},  // R3 pass 1 so far
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,12'd1,   4'd5},  // R5 fail sampled
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,12'd30,  4'd5},  // R5 sticky
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,12'd2,   4'd1}   // R1
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bist_busy = 1'b0;
    logic extract_strobe = 1'b0;
    logic bist_pass = 1'b0;
    logic retire = 1'b0;
    logic stat_pin;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    stat_pin_ctrl u_dut (
        .clk            (clk),
        .rst            (rst),
        .bist_busy      (bist_busy),
        .extract_strobe (extract_strobe),
        .bist_pass      (bist_pass),
        .retire         (retire),
        .stat_pin       (stat_pin)
    );

    task automatic run_vec(input vec_t v);
        for (int i = 0; i < int'(v.reps); i++) begin
            rst            = v.rst;
            bist_busy      = v.busy;
            extract_strobe = v.strb;
            bist_pass      = v.pass;
            retire         = v.ret;
            @(posedge clk);
            #2;
            n_cmp++;
            if (stat_pin !== v.exp) begin
                n_bad++;
                $display("FAIL R%0d: stat_pin=%b expected %b (repeat %0d)",
                         v.req, stat_pin, v.exp, i);
            end
        end
    endtask

    task automatic step(input logic r, input logic b, input logic s,
                        input logic p, input logic t, input logic e,
                        input int n, input int q);
        vec_t v;
        v = '{r, b, s, p, t, e, 12'(n), 4'(q)};
        run_vec(v);
    endtask

    initial begin
        // pin after the very first reset edge
        rst = 1'b1;
        @(posedge clk);
        #2;
        n_cmp++;
        if (stat_pin !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: stat_pin=%b expected 0 after first reset edge", stat_pin);
        end

        for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

        // Directed: reset in the middle of a watchdog pulse (R1)
        step(1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,   2, 1);
        step(1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,   1, 3);
        step(1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,  15, 3);
        step(1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,   1, 4);
        step(1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2047, 6);
        step(1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,   2, 6);
        step(1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,   1, 1);  // R1 cut by reset
        step(1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2100, 9);  // R9 idle after reset

        // Directed: busy drops without strobe, then resumes (R2)
        step(1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,   3, 2);
        step(1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,   3, 2);
        step(1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,   3, 2);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule